// File: doc/BRIEF.md
# GPIO Bank Controller

This block is a bank of general-purpose I/O pins, up to 32, set up through a 32-bit word bus. The bus has a word address, a write strobe, write data and a combinational read-data return. Each pin has its own bit in every register. Per pin, the block holds whether the pin serves general I/O or feeds an interrupt input, its direction, the value it drives, and the polarity of its input path. From these it drives the pad output value and the pad output enable. It also synchronizes the pad inputs into a readable input-data register.

Build parameters set the pin count and three options. The first selects whether input data shows the pad level on output pins or reads 0 there. The second adds a per-pin input-enable gate. The third adds a per-pin output-data-select register that forces the driven value low. Interrupt detection sits in another block, so the interrupt-related word addresses read 0 here. Software uses the block the usual way. It writes the output value first, then sets the direction. It reads pins back through the input-data word.

Top module: `gpio_bank_ctl`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is all 0 and `pad_out` is all 0. While no pin is enabled, the input-data word reads 0 whatever the pad levels are.
- R2: A write replaces the whole register at the word address given. Readback returns that value at word addresses 0 (mode: 1 = interrupt input, 0 = general I/O), 1 (direction: 1 = output), 2 (output data), 8 (polarity: 1 = inverted), 16 (output-data select) and 20 (input enable). Bits at or above NPINS are not stored and read 0.
- R3: `pad_oe[n]` is 1 exactly when direction bit n is 1 and mode bit n is 0.
- R4: `pad_out[n]` equals output-data bit n when output-data-select bit n is 0. It is 0 when that select bit is 1.
- R5: A pad level reaches the input-data word (word address 3) on the third rising clock edge after it is applied. Reads after the first and second of those edges still return the previous value.
- R6: When polarity bit n is 1, input-data bit n shows the inverse of the pad level. When it is 0, the bit shows the pad level unchanged.
- R7: With ALWAYS_IN=1, input data shows the pad level for output pins too. With ALWAYS_IN=0, input-data bits read 0 for pins whose direction bit is 1.
- R8: With HAS_INEN=1, an input-data bit updates only while input-enable bit n is 1, and otherwise keeps its last sampled value. With HAS_INEN=0, all pins are always sampled and word 20 reads 0.
- R9: Word addresses other than 0, 1, 2, 3, 8, 16 and 20 read 0, and writes to them change no register and no pad output. Writes to word 3 are ignored. With HAS_OSEL=0, word 16 reads 0 and a write to it leaves `pad_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Word address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | NPINS | Pad input levels (asynchronous) |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables |

## Verification
Every cycle, the assertions check several things. A write lands in the addressed register, and a write to an unused address changes nothing. The output enable never asserts on an interrupt-mode or input pin. A forced-low pin never drives 1. Each enabled input-data bit equals the pad level from three edges back, polarity applied, and each disabled bit holds its value. With the always-in option off, an output pin never reads 1. The directed scenarios show what a single property cannot: the exact read cycle of a new level, masking of bits above the pin count, and the behaviour of a build with the options absent.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    WA_MODE = 5'd0,
    WA_DIR  = 5'd1,
    WA_DOUT = 5'd2,
    WA_DIN  = 5'd3,
    WA_POL  = 5'd8,
    WA_OSEL = 5'd16,
    WA_INEN = 5'd20
  } word_addr_e;

  function automatic logic [WORD_W-1:0] f_oe(input logic [WORD_W-1:0] dir,
                                              input logic [WORD_W-1:0] mode);
    return dir & ~mode;
  endfunction

  function automatic logic [WORD_W-1:0] f_drive(input logic [WORD_W-1:0] dout,
                                                 input logic [WORD_W-1:0] osel);
    return dout & ~osel;
  endfunction

  function automatic logic [WORD_W-1:0] f_in_view(input logic [WORD_W-1:0] lvl,
                                                   input logic [WORD_W-1:0] dir,
                                                   input logic always_in);
    return always_in ? lvl : (lvl & ~dir);
  endfunction
endpackage

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter bit HAS_INEN = 1'b1,
  parameter bit HAS_OSEL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [NPINS-1:0]  mode_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  dout_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  osel_q,
  output logic [NPINS-1:0]  inen_q
);
  logic [NPINS-1:0] wbits;
  logic wr_mode, wr_dir, wr_dout, wr_pol, wr_osel, wr_inen;

  assign wbits   = wdata[NPINS-1:0];
  assign wr_mode = wr && (addr == WA_MODE);
  assign wr_dir  = wr && (addr == WA_DIR);
  assign wr_dout = wr && (addr == WA_DOUT);
  assign wr_pol  = wr && (addr == WA_POL);
  assign wr_osel = wr && (addr == WA_OSEL);
  assign wr_inen = wr && (addr == WA_INEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wbits;
      if (wr_dir)  dir_q  <= wbits;
      if (wr_dout) dout_q <= wbits;
      if (wr_pol)  pol_q  <= wbits;
    end
  end

  generate
    if (HAS_OSEL) begin : g_osel
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       osel_q <= '0;
        else if (wr_osel) osel_q <= wbits;
      end
    end else begin : g_no_osel
      assign osel_q = '0;
    end

    if (HAS_INEN) begin : g_inen
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       inen_q <= '0;
        else if (wr_inen) inen_q <= wbits;
      end
    end else begin : g_no_inen
      assign inen_q = '0;
    end
  endgenerate
endmodule

// File: rtl/gpio_bank_input.sv
module gpio_bank_input #(
  parameter int NPINS    = 32,
  parameter bit HAS_INEN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic [NPINS-1:0] pol_q,
  input  logic [NPINS-1:0] inen_q,
  output logic [NPINS-1:0] sample_en,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] din_q
);
  logic [NPINS-1:0] meta_q, sync_q;

  generate
    if (HAS_INEN) begin : g_gate
      assign sample_en = inen_q;
    end else begin : g_open
      assign sample_en = '1;
    end
  endgenerate

  assign lvl = sync_q ^ pol_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            din_q[n] <= 1'b0;
      else if (sample_en[n]) din_q[n] <= lvl[n];
    end
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter bit ALWAYS_IN = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  mode_q,
  input  logic [NPINS-1:0]  dir_q,
  input  logic [NPINS-1:0]  dout_q,
  input  logic [NPINS-1:0]  pol_q,
  input  logic [NPINS-1:0]  osel_q,
  input  logic [NPINS-1:0]  inen_q,
  input  logic [NPINS-1:0]  din_q,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] din_w, dir_w;

  assign din_w = WORD_W'(din_q);
  assign dir_w = WORD_W'(dir_q);

  always_comb begin
    unique case (addr)
      WA_MODE: rdata = WORD_W'(mode_q);
      WA_DIR:  rdata = dir_w;
      WA_DOUT: rdata = WORD_W'(dout_q);
      WA_DIN:  rdata = f_in_view(din_w, dir_w, ALWAYS_IN);
      WA_POL:  rdata = WORD_W'(pol_q);
      WA_OSEL: rdata = WORD_W'(osel_q);
      WA_INEN: rdata = WORD_W'(inen_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_bank_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter bit ALWAYS_IN = 1'b1,
  parameter bit HAS_INEN  = 1'b1,
  parameter bit HAS_OSEL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);
  logic [NPINS-1:0] mode_q, dir_q, dout_q, pol_q, osel_q, inen_q;
  logic [NPINS-1:0] sample_en, lvl, din_q;
  logic [WORD_W-1:0] oe_w, drv_w;

  gpio_bank_regs #(.NPINS(NPINS), .HAS_INEN(HAS_INEN), .HAS_OSEL(HAS_OSEL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q), .pol_q(pol_q),
    .osel_q(osel_q), .inen_q(inen_q)
  );

  gpio_bank_input #(.NPINS(NPINS), .HAS_INEN(HAS_INEN)) u_input (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pol_q(pol_q), .inen_q(inen_q),
    .sample_en(sample_en), .lvl(lvl), .din_q(din_q)
  );

  gpio_bank_rdmux #(.NPINS(NPINS), .ALWAYS_IN(ALWAYS_IN)) u_rdmux (
    .addr(bus_addr), .mode_q(mode_q), .dir_q(dir_q), .dout_q(dout_q),
    .pol_q(pol_q), .osel_q(osel_q), .inen_q(inen_q), .din_q(din_q),
    .rdata(bus_rdata)
  );

  assign oe_w    = f_oe(WORD_W'(dir_q), WORD_W'(mode_q));
  assign drv_w   = f_drive(WORD_W'(dout_q), WORD_W'(osel_q));
  assign pad_oe  = oe_w[NPINS-1:0];
  assign pad_out = drv_w[NPINS-1:0];
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int NPINS     = 32,
  parameter bit ALWAYS_IN = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  dout_q,
  input logic [NPINS-1:0]  pol_q,
  input logic [NPINS-1:0]  osel_q,
  input logic [NPINS-1:0]  inen_q,
  input logic [NPINS-1:0]  sample_en,
  input logic [NPINS-1:0]  din_q
);
  logic [1:0] since_rst;
  logic       unused_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  assign unused_addr = !(bus_addr inside {WA_MODE, WA_DIR, WA_DOUT, WA_DIN,
                                          WA_POL, WA_OSEL, WA_INEN});

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (pad_oe == '0 && pad_out == '0 && din_q == '0);
    end
  end

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WA_DIR) |=> (dir_q == $past(bus_wdata[NPINS-1:0])));

  a_r2_dout_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == WA_DOUT) |=> (dout_q == $past(bus_wdata[NPINS-1:0])));

  a_r3_oe_safe: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & mode_q) == '0) && ((pad_oe & ~dir_q) == '0));

  a_r4_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & osel_q) == '0);

  a_r5_sample_path: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3) |->
      (din_q == (($past(sample_en) & ($past(pad_in, 3) ^ $past(pol_q))) |
                 (~$past(sample_en) & $past(din_q)))));

  a_r7_out_pins_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!ALWAYS_IN && bus_addr == WA_DIN) |-> ((bus_rdata[NPINS-1:0] & dir_q) == '0));

  a_r9_unused_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && unused_addr) |=>
      ($stable(mode_q) && $stable(dir_q) && $stable(dout_q) && $stable(pol_q) &&
       $stable(osel_q) && $stable(inen_q)));
endmodule

bind gpio_bank_ctl gpio_bank_chk #(.NPINS(NPINS), .ALWAYS_IN(ALWAYS_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
  .pad_out(pad_out), .pad_oe(pad_oe), .mode_q(mode_q), .dir_q(dir_q),
  .dout_q(dout_q), .pol_q(pol_q), .osel_q(osel_q), .inen_q(inen_q),
  .sample_en(sample_en), .din_q(din_q)
);

// File: tb/gpio_bank_ctl_test.sv
module gpio_bank_ctl_test;
  localparam int NP  = 20;
  localparam int NPB = 8;
  localparam logic [31:0] PMASK = (32'd1 << NP) - 32'd1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [4:0]    a_addr = '0;
  logic          a_wr = 1'b0;
  logic [31:0]   a_wdata = '0;
  logic [31:0]   a_rdata;
  logic [NP-1:0] a_pin = 20'hA5A5A;
  logic [NP-1:0] a_pout, a_poe;

  logic [4:0]     b_addr = '0;
  logic           b_wr = 1'b0;
  logic [31:0]    b_wdata = '0;
  logic [31:0]    b_rdata;
  logic [NPB-1:0] b_pin = 8'hFF;
  logic [NPB-1:0] b_pout, b_poe;

  gpio_bank_ctl #(.NPINS(NP), .ALWAYS_IN(1'b1), .HAS_INEN(1'b1), .HAS_OSEL(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_wr(a_wr), .bus_wdata(a_wdata),
    .bus_rdata(a_rdata), .pad_in(a_pin), .pad_out(a_pout), .pad_oe(a_poe)
  );

  gpio_bank_ctl #(.NPINS(NPB), .ALWAYS_IN(1'b0), .HAS_INEN(1'b0), .HAS_OSEL(1'b0)) uut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr), .bus_wdata(b_wdata),
    .bus_rdata(b_rdata), .pad_in(b_pin), .pad_out(b_pout), .pad_oe(b_poe)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_a(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk); a_addr = ad; a_wdata = d; a_wr = 1'b1;
    @(negedge clk); a_wr = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] ad, output logic [31:0] d);
    @(negedge clk); a_addr = ad; #1; d = a_rdata;
  endtask

  task automatic wr_b(input logic [4:0] ad, input logic [31:0] d);
    @(negedge clk); b_addr = ad; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  task automatic rd_b(input logic [4:0] ad, output logic [31:0] d);
    @(negedge clk); b_addr = ad; #1; d = b_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    settle();
    check("R1", "pad_oe after reset", 32'(a_poe), 32'h0);
    check("R1", "pad_out after reset", 32'(a_pout), 32'h0);
    rd_a(5'd1, v); check("R1", "direction after reset", v, 32'h0);
    rd_a(5'd20, v); check("R1", "input enable after reset", v, 32'h0);
    rd_a(5'd3, v); check("R8", "input data with no pin enabled", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr_a(5'd0, 32'hFFF0_0F0F); rd_a(5'd0, v);
    check("R2", "mode readback masked", v, 32'hFFF0_0F0F & PMASK);
    wr_a(5'd0, 32'h0);
    wr_a(5'd8, 32'h1234_5678); rd_a(5'd8, v);
    check("R2", "polarity readback", v, 32'h1234_5678 & PMASK);
    wr_a(5'd8, 32'h0);
    wr_a(5'd16, 32'hDEAD_BEEF); rd_a(5'd16, v);
    check("R2", "select readback", v, 32'hDEAD_BEEF & PMASK);
    wr_a(5'd16, 32'h0);
  endtask

  task automatic t_oe();
    wr_a(5'd1, 32'h000F_F00F);
    wr_a(5'd0, 32'h0000_0003);
    @(negedge clk);
    check("R3", "oe skips interrupt-mode pins", 32'(a_poe), 32'h000F_F00C);
    wr_a(5'd0, 32'h0);
    @(negedge clk);
    check("R3", "oe follows direction", 32'(a_poe), 32'h000F_F00F);
  endtask

  task automatic t_osel();
    wr_a(5'd2, 32'h000A_BCDE);
    @(negedge clk);
    check("R4", "pad_out follows output data", 32'(a_pout), 32'h000A_BCDE);
    wr_a(5'd16, 32'h0000_00FF);
    @(negedge clk);
    check("R4", "selected pins forced low", 32'(a_pout), 32'h000A_BC00);
    wr_a(5'd16, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr_a(5'd20, PMASK);
    @(negedge clk); a_pin = 20'h11111;
    settle();
    @(negedge clk); a_pin = 20'h2C3C4;
    a_addr = 5'd3;
    @(negedge clk); #1; v = a_rdata;
    check("R5", "one edge after change", v, 32'h11111);
    @(negedge clk); #1; v = a_rdata;
    check("R5", "two edges after change", v, 32'h11111);
    @(negedge clk); #1; v = a_rdata;
    check("R5", "three edges after change", v, 32'h2C3C4);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    wr_a(5'd8, 32'h0000_F00F);
    settle();
    rd_a(5'd3, v);
    check("R6", "inverted pins", v, (32'h2C3C4 ^ 32'h0000_F00F) & PMASK);
    wr_a(5'd8, 32'h0);
  endtask

  task automatic t_always_in();
    logic [31:0] v;
    wr_a(5'd1, PMASK);
    @(negedge clk); a_pin = 20'h5A5A5;
    settle();
    rd_a(5'd3, v);
    check("R7", "always-in shows output pins", v, 32'h5A5A5);
    wr_b(5'd1, 32'h0000_000F);
    settle();
    rd_b(5'd3, v);
    check("R7", "output pins read zero", v, 32'h0000_00F0);
    rd_b(5'd20, v);
    check("R8", "no-enable build reads zero at 20", v, 32'h0);
  endtask

  task automatic t_inen();
    logic [31:0] v;
    wr_a(5'd20, 32'h0000_00FF);
    @(negedge clk); a_pin = 20'hA5A5A;
    settle();
    rd_a(5'd3, v);
    check("R8", "disabled pins hold", v, (32'h5A5A5 & 32'hFFF00) | (32'hA5A5A & 32'hFF));
  endtask

  task automatic t_unused();
    logic [31:0] v;
    logic [NP-1:0] oe0, out0;
    oe0 = a_poe; out0 = a_pout;
    wr_a(5'd4, 32'hFFFF_FFFF);
    wr_a(5'd9, 32'hFFFF_FFFF);
    wr_a(5'd31, 32'hFFFF_FFFF);
    wr_a(5'd3, 32'h0);
    @(negedge clk);
    check("R9", "oe unchanged by unused writes", 32'(a_poe), 32'(oe0));
    check("R9", "out unchanged by unused writes", 32'(a_pout), 32'(out0));
    rd_a(5'd4, v); check("R9", "word 4 reads zero", v, 32'h0);
    rd_a(5'd31, v); check("R9", "word 31 reads zero", v, 32'h0);
    rd_a(5'd1, v); check("R9", "direction kept", v, PMASK);
    rd_a(5'd3, v); check("R9", "input data kept", v, (32'h5A5A5 & 32'hFFF00) | (32'hA5A5A & 32'hFF));
    wr_b(5'd2, 32'h0000_0055);
    wr_b(5'd16, 32'h0000_00FF);
    @(negedge clk);
    check("R9", "absent select leaves pad_out", 32'(b_pout), 32'h55);
    rd_b(5'd16, v); check("R9", "absent select reads zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_oe();
    t_osel();
    t_latency();
    t_polarity();
    t_always_in();
    t_inen();
    t_unused();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'h1, 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule